// File: doc/BRIEF.md
# Shared Almost-Full Flag Bus Scanner

This block places one device's per-queue almost-full flags on a flag bus that several devices share. It runs on the write clock. It has two modes, and the mode is fixed while reset is asserted.

In direct mode, a strobe on the write port chooses which device drives the bus. The upper field of the write address gives a device identifier. The device whose identifier matches that field takes the bus, and it keeps driving until a later strobe names another device.

In polled mode, a single-cycle token goes round a chain of devices. The device that receives the token drives its flags for one write-clock cycle. During that cycle it raises a sync output and passes the token on. The last device in the chain feeds the token back to the first, so the scan never stops.

When a device is not driving, it marks the bus as released (enable low) and drives zeros on it.

Top module: `flag_bus_scanner`

## Requirements
- R1: While reset is asserted, bus_en_o, sync_o and token_o are 0 and flag_bus_o is all zeros.
- R2: In polled mode, token_i high at a rising edge makes the device drive in the following cycle. In that cycle bus_en_o=1, sync_o=1 and flag_bus_o equals the flags sampled at that edge. If no further token arrives, driving lasts exactly one cycle.
- R3: In polled mode, token_o is high in exactly the cycles in which sync_o is high.
- R4: In polled mode, a device with first_dev_i=1 drives at the first rising edge after reset is released, with no token on its input. A device with first_dev_i=0 does not.
- R5: When token_o loops back to token_i, through a single device or through a chain, the device drives once per loop period. With N cycles of delay in the loop, the period is N+1 cycles.
- R6: In direct mode, a strobe at a rising edge with prog_done_i=1 selects this device when wr_addr_i[ADDR_W-1:ADDR_W-ID_W] equals dev_id_i, and deselects it otherwise. While selected, from the next cycle on, bus_en_o=1 and flag_bus_o shows the flags sampled at the most recent edge.
- R7: In direct mode, a strobe is ignored while prog_done_i=0, and the bus state does not change.
- R8: In direct mode, token_i is ignored and sync_o and token_o stay 0. In polled mode, strobe_i is ignored.
- R9: Whenever bus_en_o is 0, flag_bus_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| polled_mode_i | input | 1 | 1 = polled token mode, 0 = direct mode |
| first_dev_i | input | 1 | Device holds the token after reset |
| dev_id_i | input | ID_W | Identifier of this device |
| prog_done_i | input | 1 | Device programming finished |
| strobe_i | input | 1 | Direct-mode select strobe |
| wr_addr_i | input | ADDR_W | Write address; upper ID_W bits are the device field |
| flags_i | input | NUM_QUEUES | Per-queue almost-full flags |
| token_i | input | 1 | Token from the previous device |
| token_o | output | 1 | Token to the next device |
| flag_bus_o | output | NUM_QUEUES | Flag bus data |
| bus_en_o | output | 1 | Flag bus is being driven |
| sync_o | output | 1 | This device's flags are on the bus |

## Verification
Every result arrives one rising edge after its cause. A token or a valid strobe seen at edge k changes the outputs in the cycle that starts at edge k. The first device drives right after the first edge following reset release. The bench changes inputs only on falling edges and steps one whole cycle, from falling edge to falling edge, before it samples. Each observation therefore falls in the cycle right after the capturing edge. Ring tests model the rest of the chain with a history of token_o, so the expected drive cycle can be computed as the loop delay plus one.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  typedef enum logic {
    FBS_DIRECT = 1'b0,
    FBS_POLLED = 1'b1
  } fbs_mode_e;
endpackage

// File: rtl/fbs_token_ring.sv
module fbs_token_ring (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic first_i,
  input  logic token_i,
  output logic take_o,
  output logic drv_o
);
  logic pend_q, drv_q;

  // pending token held only by the designated first device
  assign take_o = active_i & (pend_q | token_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= first_i;
      drv_q  <= 1'b0;
    end else begin
      pend_q <= 1'b0;
      drv_q  <= take_o;
    end
  end

  assign drv_o = drv_q;
endmodule

// File: rtl/fbs_direct_sel.sv
module fbs_direct_sel #(
  parameter int ID_W   = 3,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              prog_done_i,
  input  logic              strobe_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [ID_W-1:0]   dev_id_i,
  output logic              sel_nxt_o
);
  logic sel_q;
  logic hit;
  logic id_eq;

  assign id_eq = (wr_addr_i[ADDR_W-1 -: ID_W] == dev_id_i);
  assign hit   = active_i & strobe_i & prog_done_i;

  always_comb begin
    if (!active_i)  sel_nxt_o = 1'b0;
    else if (hit)   sel_nxt_o = id_eq;
    else            sel_nxt_o = sel_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= sel_nxt_o;
  end
endmodule

// File: rtl/fbs_bus_reg.sv
module fbs_bus_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] bus_o,
  output logic         en_o
);
  logic [W-1:0] bus_q;
  logic         en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_q <= '0;
      en_q  <= 1'b0;
    end else begin
      bus_q <= load_i ? data_i : '0;
      en_q  <= load_i;
    end
  end

  assign bus_o = bus_q;
  assign en_o  = en_q;
endmodule

// File: rtl/flag_bus_scanner.sv
module flag_bus_scanner #(
  parameter int NUM_QUEUES = 8,
  parameter int ID_W       = 3,
  localparam int QSEL_W    = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1,
  localparam int ADDR_W    = ID_W + QSEL_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  polled_mode_i,
  input  logic                  first_dev_i,
  input  logic [ID_W-1:0]       dev_id_i,
  input  logic                  prog_done_i,
  input  logic                  strobe_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [NUM_QUEUES-1:0] flags_i,
  input  logic                  token_i,
  output logic                  token_o,
  output logic [NUM_QUEUES-1:0] flag_bus_o,
  output logic                  bus_en_o,
  output logic                  sync_o
);
  import fbs_pkg::*;

  fbs_mode_e mode;
  logic      polled, direct;
  logic      take, drv, sel_nxt, load;

  assign mode   = fbs_mode_e'(polled_mode_i);
  assign polled = (mode == FBS_POLLED);
  assign direct = (mode == FBS_DIRECT);

  fbs_token_ring u_ring (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (polled),
    .first_i  (first_dev_i),
    .token_i  (token_i),
    .take_o   (take),
    .drv_o    (drv)
  );

  fbs_direct_sel #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (direct),
    .prog_done_i (prog_done_i),
    .strobe_i    (strobe_i),
    .wr_addr_i   (wr_addr_i),
    .dev_id_i    (dev_id_i),
    .sel_nxt_o   (sel_nxt)
  );

  assign load = polled ? take : sel_nxt;

  fbs_bus_reg #(.W(NUM_QUEUES)) u_bus (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (flags_i),
    .bus_o  (flag_bus_o),
    .en_o   (bus_en_o)
  );

  // token and sync both mark the single polled drive cycle
  assign token_o = drv;
  assign sync_o  = drv;
endmodule

// File: rtl/fbs_checker.sv
module fbs_checker #(
  parameter int NUM_QUEUES = 8,
  parameter int ID_W       = 3,
  parameter int ADDR_W     = 6
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  polled_mode_i,
  input logic [ID_W-1:0]       dev_id_i,
  input logic                  prog_done_i,
  input logic                  strobe_i,
  input logic [ADDR_W-1:0]     wr_addr_i,
  input logic                  token_i,
  input logic                  token_o,
  input logic [NUM_QUEUES-1:0] flag_bus_o,
  input logic                  bus_en_o,
  input logic                  sync_o
);
  always_comb begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (!bus_en_o && !sync_o && !token_o && flag_bus_o == '0);
    end
  end

  assert_token_drives_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (polled_mode_i && token_i) |=> (bus_en_o && sync_o));

  assert_single_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (polled_mode_i && sync_o && !token_i) |=> !sync_o);

  assert_token_sync_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    polled_mode_i |-> (token_o == sync_o));

  assert_direct_select_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!polled_mode_i && strobe_i && prog_done_i && wr_addr_i[ADDR_W-1 -: ID_W] == dev_id_i)
    |=> bus_en_o);

  assert_unprog_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!polled_mode_i && strobe_i && !prog_done_i && $past(rst_ni)) |=> $stable(bus_en_o));

  assert_direct_no_token_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !polled_mode_i |-> (!sync_o && !token_o));

  assert_release_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_en_o |-> (flag_bus_o == '0));
endmodule

bind flag_bus_scanner fbs_checker #(
  .NUM_QUEUES(NUM_QUEUES), .ID_W(ID_W), .ADDR_W(ADDR_W)
) u_fbs_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .polled_mode_i (polled_mode_i),
  .dev_id_i      (dev_id_i),
  .prog_done_i   (prog_done_i),
  .strobe_i      (strobe_i),
  .wr_addr_i     (wr_addr_i),
  .token_i       (token_i),
  .token_o       (token_o),
  .flag_bus_o    (flag_bus_o),
  .bus_en_o      (bus_en_o),
  .sync_o        (sync_o)
);

// File: tb/flag_bus_scanner_bench.sv
module flag_bus_scanner_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NQ   = 8;
  localparam int IDW  = 3;
  localparam int AW   = IDW + $clog2(NQ);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          polled_mode_i = 1'b0;
  logic          first_dev_i = 1'b0;
  logic [IDW-1:0] dev_id_i = '0;
  logic          prog_done_i = 1'b0;
  logic          strobe_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [NQ-1:0] flags_i = '0;
  logic          token_i = 1'b0;
  logic          token_o, bus_en_o, sync_o;
  logic [NQ-1:0] flag_bus_o;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_bus_scanner #(.NUM_QUEUES(NQ), .ID_W(IDW)) u_flag_bus_scanner (
    .clk_i(clk), .rst_ni(rst_ni), .polled_mode_i(polled_mode_i),
    .first_dev_i(first_dev_i), .dev_id_i(dev_id_i), .prog_done_i(prog_done_i),
    .strobe_i(strobe_i), .wr_addr_i(wr_addr_i), .flags_i(flags_i),
    .token_i(token_i), .token_o(token_o), .flag_bus_o(flag_bus_o),
    .bus_en_o(bus_en_o), .sync_o(sync_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // packed view {en,sync,token,bus}
  function automatic int outs();
    return {21'd0, bus_en_o, sync_o, token_o, flag_bus_o};
  endfunction

  function automatic int mk(bit en, bit sy, bit tk, logic [NQ-1:0] b);
    return {21'd0, en, sy, tk, b};
  endfunction

  task automatic do_reset(input bit polled, input bit first);
    @(negedge clk);
    rst_ni = 1'b0;
    polled_mode_i = polled;
    first_dev_i = first;
    strobe_i = 1'b0;
    token_i = 1'b0;
    prog_done_i = 1'b0;
    step();
    step();
    chk(outs() == mk(0, 0, 0, '0), "R1 reset outputs", outs(), mk(0, 0, 0, '0));
    rst_ni = 1'b1;
  endtask

  task automatic t_first_device();
    flags_i = 8'h96;
    do_reset(1'b1, 1'b1);
    step();
    chk(outs() == mk(1, 1, 1, 8'h96), "R4 first device drives after reset", outs(), mk(1, 1, 1, 8'h96));
    step();
    chk(outs() == mk(0, 0, 0, '0), "R2 R9 single drive then released", outs(), mk(0, 0, 0, '0));
    do_reset(1'b1, 1'b0);
    step();
    chk(outs() == mk(0, 0, 0, '0), "R4 non-first device stays quiet", outs(), mk(0, 0, 0, '0));
  endtask

  task automatic t_token_pass();
    do_reset(1'b1, 1'b0);
    step();
    flags_i = 8'hA5;
    token_i = 1'b1;
    step();
    chk(outs() == mk(1, 1, 1, 8'hA5), "R2 R3 token drives flags", outs(), mk(1, 1, 1, 8'hA5));
    token_i = 1'b0;
    flags_i = 8'h3C;
    step();
    chk(outs() == mk(0, 0, 0, '0), "R2 drive lasts one cycle", outs(), mk(0, 0, 0, '0));
    // polled mode: strobe addressing this device has no effect
    dev_id_i = 3'd4;
    prog_done_i = 1'b1;
    strobe_i = 1'b1;
    wr_addr_i = {3'd4, 3'd1};
    step();
    strobe_i = 1'b0;
    step();
    chk(outs() == mk(0, 0, 0, '0), "R8 strobe ignored in polled mode", outs(), mk(0, 0, 0, '0));
  endtask

  task automatic t_ring();
    logic [2:0] h;
    int errs;
    int hits;
    do_reset(1'b1, 1'b1);
    h = '0;
    errs = 0;
    hits = 0;
    for (int k = 1; k <= 16; k++) begin
      step();
      if (sync_o !== (((k - 1) % 4) == 0)) errs++;
      if (sync_o) hits++;
      token_i = h[2];
      h = {h[1:0], token_o};
    end
    token_i = 1'b0;
    chk(errs == 0, "R5 ring period four with three-cycle loop", errs, 0);
    chk(hits == 4, "R5 four drives in sixteen cycles", hits, 4);
    // single device: token looped straight back
    do_reset(1'b1, 1'b1);
    errs = 0;
    for (int k = 1; k <= 6; k++) begin
      step();
      if (!(bus_en_o && sync_o && token_o)) errs++;
      token_i = token_o;
    end
    token_i = 1'b0;
    chk(errs == 0, "R5 self loop drives every cycle", errs, 0);
  endtask

  task automatic t_direct();
    do_reset(1'b0, 1'b0);
    dev_id_i = 3'd5;
    flags_i = 8'h5A;
    strobe_i = 1'b1;
    wr_addr_i = {3'd5, 3'd2};
    step();
    strobe_i = 1'b0;
    chk(outs() == mk(0, 0, 0, '0), "R7 strobe before programming ignored", outs(), mk(0, 0, 0, '0));
    prog_done_i = 1'b1;
    strobe_i = 1'b1;
    step();
    strobe_i = 1'b0;
    chk(outs() == mk(1, 0, 0, 8'h5A), "R6 matching strobe selects", outs(), mk(1, 0, 0, 8'h5A));
    flags_i = 8'hC3;
    token_i = 1'b1;
    step();
    chk(outs() == mk(1, 0, 0, 8'hC3), "R6 R8 tracks flags, token ignored", outs(), mk(1, 0, 0, 8'hC3));
    token_i = 1'b0;
    prog_done_i = 1'b0;
    strobe_i = 1'b1;
    wr_addr_i = {3'd2, 3'd0};
    step();
    strobe_i = 1'b0;
    chk(bus_en_o == 1'b1, "R7 deselect ignored without programming", bus_en_o, 1);
    prog_done_i = 1'b1;
    strobe_i = 1'b1;
    step();
    strobe_i = 1'b0;
    chk(outs() == mk(0, 0, 0, '0), "R6 R9 other id releases bus", outs(), mk(0, 0, 0, '0));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_first_device();
    t_token_pass();
    t_ring();
    t_direct();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule